// File: doc/BRIEF.md
# Two-Level Interrupt Poll and Vector Controller

This block decides, once per machine cycle, whether an 8-bit core must take a hardware call into an interrupt routine, and which source it serves. Every cycle it captures the request flags into a snapshot register. The next cycle's decision is made from that snapshot, the per-source enable and level bits, and a global enable. A call can be issued only in the cycle the core marks as the last cycle of an instruction. It is held back if that instruction is a return-from-interrupt or a write to the enable or level registers. This lets the core run one more instruction after any change to the interrupt state.

Two in-service bits record which levels are active. Only a return-from-interrupt releases a level, never an ordinary return. The block keeps no record of requests it could not take. A request that disappears while it is blocked is lost.

The call request is a single-cycle pulse with the source index, and it cannot be back-pressured: the core takes it unconditionally. The pulse comes with a one-cycle clear strobe for sources whose flags the hardware clears itself. The parameter `AUTO_CLR` selects those sources. With the default, sources 0, 2 and 4 are cleared by hardware and the others are left to software.

Top module: `irq_poll_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `vec_fire` and `flag_clr` are zero, and no level is in service.
- R2: A decision uses the `irq_flag` values captured at the previous clock edge. A flag that is first high just before edge k can produce `vec_fire` no earlier than the cycle after edge k+1.
- R3: `vec_fire` rises only in the cycle after an edge at which `instr_last` was 1.
- R4: No call is issued at a boundary where `instr_reti` or `instr_ie_wr` is 1. The next boundary without either one may issue the call.
- R5: A request that was blocked and is no longer in the snapshot at a later boundary is never served.
- R6: A source takes part only when `glob_en` and its bit in `irq_en` are both 1.
- R7: An eligible source with `irq_pri` bit 1 (high) beats any source with `irq_pri` bit 0 (low). Within a level, the lowest index wins.
- R8: While the high level is in service, no call is issued. While only the low level is in service, only high sources are taken.
- R9: At a boundary with `instr_reti`=1, the high in-service bit is cleared if it is set, and otherwise the low one. A boundary without `instr_reti` leaves both bits unchanged unless a call is taken.
- R10: A call shows as `vec_fire`=1 for one cycle, with `vec_idx` holding the source index and the matching in-service bit set at the same edge. `flag_clr` is one-hot on that source when its `AUTO_CLR` bit is 1, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_flag | input | N_SRC | Latched request flags |
| irq_en | input | N_SRC | Per-source enable |
| irq_pri | input | N_SRC | Per-source level, 1 = high |
| glob_en | input | 1 | Global interrupt enable |
| instr_last | input | 1 | Current cycle is the last cycle of an instruction |
| instr_reti | input | 1 | Instruction ending now is a return-from-interrupt |
| instr_ie_wr | input | 1 | Instruction ending now writes the enable or level registers |
| vec_fire | output | 1 | One-cycle vector-call request |
| vec_idx | output | $clog2(N_SRC) | Source index of the call, zero when idle |
| flag_clr | output | N_SRC | One-cycle clear strobe for auto-cleared sources |

## Verification
A single pending request is first held without an instruction boundary, and then at boundaries ended by a return or an enable write. This shows whether the snapshot delay and the boundary blocking are applied. A blocked request that is then dropped shows whether denied requests are remembered. Mixed-level and same-level request sets separate the level ordering from the index ordering. Nested routines with and without return-from-interrupt show whether the in-service bits stack and release correctly. A long random run with random enables, levels and boundary kinds is compared with a behavioural model on every cycle.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } irq_lvl_e;
endpackage

// File: rtl/irq_snap.sv
module irq_snap #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] snap_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) snap_o <= '0;
    else        snap_o <= flags_i;
  end
endmodule

// File: rtl/irq_first.sv
module irq_first #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o    = 1'b1;
        idx_o    = IW'(i);
        oh_o     = '0;
        oh_o[i]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_poll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_i,
  input  irq_lvl_e take_lvl_i,
  input  logic     reti_i,
  output logic     lo_busy_o,
  output logic     hi_busy_o
);
  logic lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else if (take_i) begin
      if (take_lvl_i == LVL_HIGH) hi_q <= 1'b1;
      else                        lo_q <= 1'b1;
    end else if (reti_i) begin
      if (hi_q) hi_q <= 1'b0;
      else      lo_q <= 1'b0;
    end
  end

  assign lo_busy_o = lo_q;
  assign hi_busy_o = hi_q;

  // R8
  hi_not_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && take_lvl_i == LVL_HIGH) |-> !hi_q);
  // R8
  lo_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && take_lvl_i == LVL_LOW) |-> (!hi_q && !lo_q));
  // R9
  reti_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && hi_q) |=> !hi_q);
  // R9
  reti_lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && !hi_q) |=> !lo_q);
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_poll_pkg::*;
#(
  parameter int          N_SRC    = 6,
  parameter int unsigned AUTO_CLR = 32'h15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         irq_flag,
  input  logic [N_SRC-1:0]         irq_en,
  input  logic [N_SRC-1:0]         irq_pri,
  input  logic                     glob_en,
  input  logic                     instr_last,
  input  logic                     instr_reti,
  input  logic                     instr_ie_wr,
  output logic                     vec_fire,
  output logic [$clog2(N_SRC)-1:0] vec_idx,
  output logic [N_SRC-1:0]         flag_clr
);
  localparam int IW = $clog2(N_SRC);
  localparam logic [N_SRC-1:0] CLR_MASK = AUTO_CLR[N_SRC-1:0];

  logic [N_SRC-1:0] snap, elig, hi_req, lo_req, hi_oh, lo_oh;
  logic [IW-1:0]    hi_idx, lo_idx;
  logic             hi_any, lo_any, lo_busy, hi_busy;
  logic             bnd_ok, take_hi, take_lo, take;
  irq_lvl_e         take_lvl;

  irq_snap #(.N(N_SRC)) u_snap (
    .clk(clk), .rst_n(rst_n), .flags_i(irq_flag), .snap_o(snap)
  );

  assign elig   = snap & irq_en & {N_SRC{glob_en}};
  assign hi_req = elig & irq_pri;
  assign lo_req = elig & ~irq_pri;

  irq_first #(.N(N_SRC), .IW(IW)) u_pick_hi (
    .req_i(hi_req), .any_o(hi_any), .idx_o(hi_idx), .oh_o(hi_oh)
  );
  irq_first #(.N(N_SRC), .IW(IW)) u_pick_lo (
    .req_i(lo_req), .any_o(lo_any), .idx_o(lo_idx), .oh_o(lo_oh)
  );

  assign bnd_ok   = instr_last && !instr_reti && !instr_ie_wr;
  assign take_hi  = bnd_ok && hi_any && !hi_busy;
  assign take_lo  = bnd_ok && !hi_any && lo_any && !hi_busy && !lo_busy;
  assign take     = take_hi || take_lo;
  assign take_lvl = take_hi ? LVL_HIGH : LVL_LOW;

  irq_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .take_i(take), .take_lvl_i(take_lvl),
    .reti_i(instr_last && instr_reti),
    .lo_busy_o(lo_busy), .hi_busy_o(hi_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_fire <= 1'b0;
      vec_idx  <= '0;
      flag_clr <= '0;
    end else begin
      vec_fire <= take;
      vec_idx  <= take_hi ? hi_idx : (take_lo ? lo_idx : '0);
      flag_clr <= take_hi ? (hi_oh & CLR_MASK) :
                  (take_lo ? (lo_oh & CLR_MASK) : '0);
    end
  end

  // R3
  fire_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |-> $past(instr_last));
  // R4
  no_fire_after_blocker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |-> !$past(instr_reti || instr_ie_wr));
  // R6
  fire_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |-> $past(glob_en));
  // R10
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr));
  // R10
  clr_only_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> vec_fire);
endmodule

// File: tb/sim_irq_poll_ctrl.sv
`timescale 1ns/1ps
module sim_irq_poll_ctrl;
  localparam int N = 6;
  localparam int IW = $clog2(N);
  localparam int unsigned CLR = 32'h15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_flag = '0, irq_en = '0, irq_pri = '0;
  logic glob_en = 1'b0, instr_last = 1'b0, instr_reti = 1'b0, instr_ie_wr = 1'b0;
  logic vec_fire;
  logic [IW-1:0] vec_idx;
  logic [N-1:0] flag_clr;

  int total = 0, bad = 0, fires = 0;
  string cur_req = "R1";
  bit done = 0;

  irq_poll_ctrl #(.N_SRC(N), .AUTO_CLR(CLR)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en),
    .irq_pri(irq_pri), .glob_en(glob_en), .instr_last(instr_last),
    .instr_reti(instr_reti), .instr_ie_wr(instr_ie_wr),
    .vec_fire(vec_fire), .vec_idx(vec_idx), .flag_clr(flag_clr)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit m_snap[N];
  bit m_hi, m_lo;
  bit e_fire;
  int e_idx;
  logic [N-1:0] e_clr;

  always @(posedge clk) begin : model
    int pick;
    bit pick_hi;
    if (!rst_n) begin
      foreach (m_snap[i]) m_snap[i] = 0;
      m_hi = 0; m_lo = 0; e_fire = 0; e_idx = 0; e_clr = '0;
    end else begin
      pick = -1; pick_hi = 0;
      if (instr_last && !instr_reti && !instr_ie_wr && !m_hi) begin
        for (int i = 0; i < N; i++)
          if (pick < 0 && m_snap[i] && glob_en && irq_en[i] && irq_pri[i]) begin
            pick = i; pick_hi = 1;
          end
        if (pick < 0 && !m_lo)
          for (int i = 0; i < N; i++)
            if (pick < 0 && m_snap[i] && glob_en && irq_en[i] && !irq_pri[i]) pick = i;
      end
      e_fire = (pick >= 0);
      e_idx  = (pick >= 0) ? pick : 0;
      e_clr  = '0;
      if (pick >= 0 && CLR[pick]) e_clr[pick] = 1'b1;
      if (pick >= 0) begin
        if (pick_hi) m_hi = 1; else m_lo = 1;
      end else if (instr_last && instr_reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      for (int i = 0; i < N; i++) m_snap[i] = irq_flag[i];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(vec_fire === e_fire, cur_req, "vec_fire", vec_fire, e_fire);
      chk(vec_idx === IW'(e_idx), cur_req, "vec_idx", vec_idx, e_idx);
      chk(flag_clr === e_clr, cur_req, "flag_clr", flag_clr, e_clr);
      if (vec_fire) fires++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd(input bit reti, input bit wr);
    instr_last = 1; instr_reti = reti; instr_ie_wr = wr;
    @(negedge clk);
    instr_last = 0; instr_reti = 0; instr_ie_wr = 0;
  endtask

  task automatic idle_all();
    irq_flag = '0;
    cyc(2);
    bnd(1, 0); bnd(1, 0);
    cyc(2);
  endtask

  int f0;

  initial begin
    // R1 reset state
    cyc(3);
    chk(vec_fire === 0, "R1", "reset vec_fire", vec_fire, 0);
    chk(flag_clr === '0, "R1", "reset flag_clr", flag_clr, 0);
    rst_n = 1;
    cyc(1);
    chk(vec_fire === 0, "R1", "post-reset vec_fire", vec_fire, 0);
    glob_en = 1; irq_en = '1; irq_pri = '0;

    // R2, R3: no call without boundary, then one call
    cur_req = "R3"; f0 = fires;
    irq_flag = 6'b000010;
    cyc(5);
    chk(fires == f0, "R3", "no boundary no call", fires - f0, 0);
    cur_req = "R2";
    bnd(0, 0); cyc(1);
    chk(fires == f0 + 1, "R2", "call after boundary", fires - f0, 1);
    idle_all();

    // R2: flag raised in same cycle as boundary is too late
    f0 = fires;
    irq_flag = 6'b000001; bnd(0, 0); cyc(1);
    chk(fires == f0, "R2", "snapshot delay", fires - f0, 0);
    idle_all();

    // R4: blockers
    cur_req = "R4"; f0 = fires;
    irq_flag = 6'b000100; cyc(2);
    bnd(1, 0); bnd(0, 1); cyc(1);
    chk(fires == f0, "R4", "blocked boundaries", fires - f0, 0);
    bnd(0, 0); cyc(1);
    chk(fires == f0 + 1, "R4", "next boundary serves", fires - f0, 1);
    idle_all();

    // R5: blocked then dropped
    cur_req = "R5"; f0 = fires;
    irq_flag = 6'b001000; cyc(2);
    bnd(0, 1);
    irq_flag = '0; cyc(2);
    bnd(0, 0); cyc(2);
    chk(fires == f0, "R5", "dropped request forgotten", fires - f0, 0);
    idle_all();

    // R6: enables
    cur_req = "R6"; f0 = fires;
    glob_en = 0; irq_flag = 6'b000011; cyc(2); bnd(0, 0); cyc(1);
    glob_en = 1; irq_en = 6'b111100; bnd(0, 0); cyc(1);
    chk(fires == f0, "R6", "disabled sources", fires - f0, 0);
    irq_en = '1;
    idle_all();

    // R7: ordering
    cur_req = "R7";
    irq_pri = 6'b100000; irq_flag = 6'b100110; cyc(2);
    bnd(0, 0); cyc(1);
    idle_all();
    irq_pri = '0; irq_flag = 6'b110100; cyc(2);
    bnd(0, 0); cyc(1);
    idle_all();

    // R8: nesting
    cur_req = "R8"; f0 = fires;
    irq_pri = 6'b010000;
    irq_flag = 6'b000010; cyc(2); bnd(0, 0);
    irq_flag = 6'b000001; cyc(2); bnd(0, 0); cyc(1);
    chk(fires == f0 + 1, "R8", "low blocks low", fires - f0, 1);
    irq_flag = 6'b010001; cyc(2); bnd(0, 0); cyc(1);
    chk(fires == f0 + 2, "R8", "high nests over low", fires - f0, 2);
    bnd(0, 0); cyc(1);
    chk(fires == f0 + 2, "R8", "high blocks all", fires - f0, 2);

    // R9: ordinary return keeps levels, reti releases in order
    cur_req = "R9"; irq_flag = 6'b010001;
    bnd(0, 0); bnd(0, 0); cyc(1);
    chk(fires == f0 + 2, "R9", "plain return keeps level", fires - f0, 2);
    irq_flag = 6'b000001;
    bnd(1, 0); bnd(0, 0); cyc(1);
    chk(fires == f0 + 2, "R9", "reti frees high only", fires - f0, 2);
    bnd(1, 0); bnd(0, 0); cyc(1);
    chk(fires == f0 + 3, "R9", "second reti frees low", fires - f0, 3);
    idle_all();

    // R10: clear strobe per source
    cur_req = "R10"; irq_pri = '0;
    for (int s = 0; s < N; s++) begin
      irq_flag = '0; irq_flag[s] = 1'b1; cyc(2);
      bnd(0, 0); cyc(1);
      idle_all();
    end

    // random traffic
    cur_req = "R7";
    for (int k = 0; k < 3000; k++) begin
      irq_flag = N'($urandom);
      if (($urandom % 8) == 0) irq_en = N'($urandom);
      if (($urandom % 8) == 0) irq_pri = N'($urandom);
      glob_en = ($urandom % 10) != 0;
      instr_last = ($urandom % 3) == 0;
      instr_reti = instr_last && (($urandom % 4) == 0);
      instr_ie_wr = instr_last && (($urandom % 6) == 0);
      @(negedge clk);
    end
    instr_last = 0; instr_reti = 0; instr_ie_wr = 0;
    cyc(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule